// File: doc/BRIEF.md
# Microsequencer with Translation Array

This block produces the control-store address for a microprogrammed processor. An 11-bit location counter holds the address of the control word now being fetched. Bits of that control word steer the counter's next value: step on by one, take a jump target, come back from a single-level return register, or take an address from a translation stage. The translation stage works like a programmable logic array.

The translation stage builds a search key from four things: the current location, the 16-bit instruction being interpreted, four microlevel interrupt lines, and three internal flags. It scans a parameterized list of (mask, value, address) entries in priority order. Because the invoking location is part of the key, the same command decodes opcodes at one address and arbitrates interrupts at another. The control word therefore needs no branch-condition field. The three flags are set and cleared by control-word bits, and the translation stage reads them.

Top module: `mseq_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the location counter, the return register and all three flags to zero, so `uaddr_o` and `flags_o` read 0 after that edge.
- R2: When none of `xlat_en_i`, `ret_load_i` or `jump_en_i` is high, `uaddr_o` becomes `uaddr_o + 1` at the next edge, wrapping from 0x7FF to 0x000.
- R3: With `jump_en_i` high and neither `xlat_en_i` nor `ret_load_i` high, `uaddr_o` takes `jump_addr_i` at the next edge.
- R4: `call_save_i` writes `uaddr_o + 1` (mod 2048) into the return register. `ret_load_i` loads the counter from the return register and wins over `jump_en_i`. When save and return fall in the same cycle, the counter takes the older return value.
- R5: While `xlat_en_i` is high, the translation stage alone decides the next address, and `jump_en_i` and `ret_load_i` have no effect on it. A save request in that cycle still takes effect.
- R6: A 1 in `flag_set_i[k]` sets flag k and a 1 in `flag_clr_i[k]` clears it. If both are 1 for the same bit, set wins. `flags_o` shows the flag register.
- R7: The translation key is 34 bits: bits [33:23] hold the location, [22:7] the instruction, [6:3] the interrupt lines and [2:0] the flags as registered before this cycle's update. Entry i matches when `(key & mask_i) == value_i`, and the lowest matching index gives the address.
- R8: If `xlat_en_i` is high and no entry matches, the counter increments by one.
- R9: The default table at location 0x010 sends interrupt 3, 2, 1, 0 to 0x700, 0x710, 0x720, 0x730 in that priority, and otherwise sends flag 0 to 0x740. At 0x020 it sends instruction bits [15:12] equal to 1 to 0x100 and equal to 2 to 0x200, and otherwise sends instruction bit 15 with flag 1 to 0x300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jump_en_i | input | 1 | Load the counter from the jump target |
| jump_addr_i | input | 11 | Jump target |
| call_save_i | input | 1 | Save current location plus one in the return register |
| ret_load_i | input | 1 | Load the counter from the return register |
| xlat_en_i | input | 1 | Invoke the translation stage |
| flag_set_i | input | 3 | Per-flag set commands |
| flag_clr_i | input | 3 | Per-flag clear commands |
| instr_i | input | 16 | Instruction being interpreted |
| irq_i | input | 4 | Microlevel interrupt lines |
| uaddr_o | output | 11 | Current control-store address |
| flags_o | output | 3 | Internal flag register |

## Verification
A translation command can share its cycle with a jump, a return or both, and only the translation result (or the increment on a miss) may win. The bench sweeps every interrupt pattern against every flag state at the interrupt-arbitration location, and every top opcode nibble against every flag state at the decode location. Jump and return are raised on patterns tied to the sweep indices while the jump target points elsewhere. Each next address is judged against an arithmetic model of the default table. Save and return in the same cycle, and set and clear of the same flag bit, are provoked separately and checked against the older return value and against set-wins.

// File: rtl/mseq_pkg.sv
// Package: shared types and the default translation table.
// Assumes the default widths: 11-bit location, 16-bit instruction,
// 4 interrupt lines, 3 flags, 8 table entries.
package mseq_pkg;

    localparam int D_AW   = 11;
    localparam int D_IW   = 16;
    localparam int D_NIRQ = 4;
    localparam int D_NFLG = 3;
    localparam int D_NENT = 8;
    localparam int D_KW   = D_AW + D_IW + D_NIRQ + D_NFLG;

    // Source chosen for the next location
    typedef enum logic [1:0] {
        SRC_INC = 2'd0,
        SRC_JMP = 2'd1,
        SRC_RET = 2'd2,
        SRC_XLT = 2'd3
    } lc_src_e;

    // Assembles one key-shaped word from its four fields
    function automatic logic [D_KW-1:0] mk_key(
        input logic [D_AW-1:0]   loc,
        input logic [D_IW-1:0]   ins,
        input logic [D_NIRQ-1:0] irq,
        input logic [D_NFLG-1:0] flg);
        return {loc, ins, irq, flg};
    endfunction

    // Entry 0 sits in the lowest bits; lower index has higher priority
    localparam logic [D_NENT*D_KW-1:0] DEF_MASK = {
        mk_key(11'h7FF, 16'h8000, 4'h0, 3'h2),
        mk_key(11'h7FF, 16'hF000, 4'h0, 3'h0),
        mk_key(11'h7FF, 16'hF000, 4'h0, 3'h0),
        mk_key(11'h7FF, 16'h0000, 4'h0, 3'h1),
        mk_key(11'h7FF, 16'h0000, 4'h1, 3'h0),
        mk_key(11'h7FF, 16'h0000, 4'h2, 3'h0),
        mk_key(11'h7FF, 16'h0000, 4'h4, 3'h0),
        mk_key(11'h7FF, 16'h0000, 4'h8, 3'h0)
    };

    localparam logic [D_NENT*D_KW-1:0] DEF_VAL = {
        mk_key(11'h020, 16'h8000, 4'h0, 3'h2),
        mk_key(11'h020, 16'h2000, 4'h0, 3'h0),
        mk_key(11'h020, 16'h1000, 4'h0, 3'h0),
        mk_key(11'h010, 16'h0000, 4'h0, 3'h1),
        mk_key(11'h010, 16'h0000, 4'h1, 3'h0),
        mk_key(11'h010, 16'h0000, 4'h2, 3'h0),
        mk_key(11'h010, 16'h0000, 4'h4, 3'h0),
        mk_key(11'h010, 16'h0000, 4'h8, 3'h0)
    };

    localparam logic [D_NENT*D_AW-1:0] DEF_ADDR = {
        11'h300, 11'h200, 11'h100, 11'h740,
        11'h730, 11'h720, 11'h710, 11'h700
    };

endpackage

// File: rtl/mseq_xlat.sv
// Module: translation stage. Forms the key from location, instruction,
// interrupts and flags, matches every entry in parallel and returns the
// address of the lowest-index hit.
// Assumes the tables hold NENT entries packed with entry 0 in the low bits.
module mseq_xlat #(
    parameter int AW   = 11,
    parameter int IW   = 16,
    parameter int NIRQ = 4,
    parameter int NFLG = 3,
    parameter int NENT = 8,
    localparam int KW  = AW + IW + NIRQ + NFLG,
    parameter logic [NENT*KW-1:0] TBL_MASK = '0,
    parameter logic [NENT*KW-1:0] TBL_VAL  = '0,
    parameter logic [NENT*AW-1:0] TBL_ADDR = '0
) (
    input  logic [AW-1:0]   loc_i,
    input  logic [IW-1:0]   instr_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic [NFLG-1:0] flags_i,
    output logic            hit_o,
    output logic [AW-1:0]   addr_o
);

    logic [KW-1:0]   key;
    logic [NENT-1:0] hit_vec;

    // Key layout: location high, then instruction, interrupts, flags
    assign key = {loc_i, instr_i, irq_i, flags_i};

    // One comparator per table entry
    for (genvar e = 0; e < NENT; e++) begin : g_ent
        assign hit_vec[e] = ((key & TBL_MASK[e*KW +: KW]) == TBL_VAL[e*KW +: KW]);
    end

    // Priority pick: scanning down lets the lowest index overwrite last
    always_comb begin
        hit_o  = |hit_vec;
        addr_o = '0;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                addr_o = TBL_ADDR[e*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/mseq_flags.sv
// Module: internal flag register. Each bit is set or cleared by the
// control word; set wins when both are asked for the same bit.
// Assumes synchronous active-low reset.
module mseq_flags #(
    parameter int NFLG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLG-1:0] set_i,
    input  logic [NFLG-1:0] clr_i,
    output logic [NFLG-1:0] flags_o
);

    // Clear first, then set, so set has the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= (flags_o & ~clr_i) | set_i;
        end
    end

endmodule

// File: rtl/mseq_lc.sv
// Module: location counter and single-level return register.
// Chooses one load source per cycle: translation, return, jump, increment.
// Assumes the translation request owns the cycle even on a miss.
module mseq_lc #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          jump_en_i,
    input  logic [AW-1:0] jump_addr_i,
    input  logic          save_i,
    input  logic          ret_i,
    input  logic          xlat_i,
    input  logic          xhit_i,
    input  logic [AW-1:0] xaddr_i,
    output logic [AW-1:0] lc_o
);
    import mseq_pkg::*;

    localparam logic [AW-1:0] LC_ONE = {{(AW-1){1'b0}}, 1'b1};

    lc_src_e       src;
    logic [AW-1:0] lc_inc;
    logic [AW-1:0] ret_q;
    logic [AW-1:0] lc_nxt;

    assign lc_inc = lc_o + LC_ONE;

    // Fixed-priority selection of the load source
    always_comb begin
        if (xlat_i && xhit_i) begin
            src = SRC_XLT;
        end else if (xlat_i) begin
            src = SRC_INC;
        end else if (ret_i) begin
            src = SRC_RET;
        end else if (jump_en_i) begin
            src = SRC_JMP;
        end else begin
            src = SRC_INC;
        end
    end

    // Mux of the chosen source onto the next location
    always_comb begin
        unique case (src)
            SRC_XLT: lc_nxt = xaddr_i;
            SRC_RET: lc_nxt = ret_q;
            SRC_JMP: lc_nxt = jump_addr_i;
            default: lc_nxt = lc_inc;
        endcase
    end

    // Location counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_o <= '0;
        end else begin
            lc_o <= lc_nxt;
        end
    end

    // Return register keeps the location after the saving word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (save_i) begin
            ret_q <= lc_inc;
        end
    end

endmodule

// File: rtl/mseq_core.sv
// Module: microsequencer top. Ties the translation stage, flag register
// and location counter together; the output is the address now fetched.
// Assumes control bits are valid for the whole cycle of their word.
module mseq_core #(
    parameter int AW   = mseq_pkg::D_AW,
    parameter int IW   = mseq_pkg::D_IW,
    parameter int NIRQ = mseq_pkg::D_NIRQ,
    parameter int NFLG = mseq_pkg::D_NFLG,
    parameter int NENT = mseq_pkg::D_NENT,
    localparam int KW  = AW + IW + NIRQ + NFLG,
    parameter logic [NENT*KW-1:0] TBL_MASK = mseq_pkg::DEF_MASK,
    parameter logic [NENT*KW-1:0] TBL_VAL  = mseq_pkg::DEF_VAL,
    parameter logic [NENT*AW-1:0] TBL_ADDR = mseq_pkg::DEF_ADDR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            jump_en_i,
    input  logic [AW-1:0]   jump_addr_i,
    input  logic            call_save_i,
    input  logic            ret_load_i,
    input  logic            xlat_en_i,
    input  logic [NFLG-1:0] flag_set_i,
    input  logic [NFLG-1:0] flag_clr_i,
    input  logic [IW-1:0]   instr_i,
    input  logic [NIRQ-1:0] irq_i,
    output logic [AW-1:0]   uaddr_o,
    output logic [NFLG-1:0] flags_o
);

    logic          xl_hit;
    logic [AW-1:0] xl_addr;

    // Translation lookup on the registered location and flags
    mseq_xlat #(
        .AW(AW), .IW(IW), .NIRQ(NIRQ), .NFLG(NFLG), .NENT(NENT),
        .TBL_MASK(TBL_MASK), .TBL_VAL(TBL_VAL), .TBL_ADDR(TBL_ADDR)
    ) u_xlat (
        .loc_i   (uaddr_o),
        .instr_i (instr_i),
        .irq_i   (irq_i),
        .flags_i (flags_o),
        .hit_o   (xl_hit),
        .addr_o  (xl_addr)
    );

    // Flags written by the control word
    mseq_flags #(.NFLG(NFLG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set_i),
        .clr_i   (flag_clr_i),
        .flags_o (flags_o)
    );

    // Counter and return register
    mseq_lc #(.AW(AW)) u_lc (
        .clk         (clk),
        .rst_n       (rst_n),
        .jump_en_i   (jump_en_i),
        .jump_addr_i (jump_addr_i),
        .save_i      (call_save_i),
        .ret_i       (ret_load_i),
        .xlat_i      (xlat_en_i),
        .xhit_i      (xl_hit),
        .xaddr_i     (xl_addr),
        .lc_o        (uaddr_o)
    );

endmodule

// File: rtl/mseq_chk.sv
// Module: property checker bound to mseq_core. Watches the ports and the
// translation stage's result over time.
module mseq_chk #(
    parameter int AW   = 11,
    parameter int NFLG = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            jump_en_i,
    input logic [AW-1:0]   jump_addr_i,
    input logic            ret_load_i,
    input logic            xlat_en_i,
    input logic [NFLG-1:0] flag_set_i,
    input logic [NFLG-1:0] flag_clr_i,
    input logic [AW-1:0]   uaddr_o,
    input logic [NFLG-1:0] flags_o,
    input logic            xl_hit,
    input logic [AW-1:0]   xl_addr
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_en_i && !ret_load_i && !jump_en_i) |=> (uaddr_o == $past(uaddr_o) + ONE)); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en_i && !xlat_en_i && !ret_load_i) |=> (uaddr_o == $past(jump_addr_i))); // R3

    AST_XLAT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_en_i && xl_hit) |=> (uaddr_o == $past(xl_addr))); // R5

    AST_MISS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_en_i && !xl_hit) |=> (uaddr_o == $past(uaddr_o) + ONE)); // R8

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set_i != '0) |=> ((flags_o & $past(flag_set_i)) == $past(flag_set_i))); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr_i & ~flag_set_i) != '0) |=> ((flags_o & $past(flag_clr_i & ~flag_set_i)) == '0)); // R6

endmodule

bind mseq_core mseq_chk #(.AW(AW), .NFLG(NFLG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .jump_en_i   (jump_en_i),
    .jump_addr_i (jump_addr_i),
    .ret_load_i  (ret_load_i),
    .xlat_en_i   (xlat_en_i),
    .flag_set_i  (flag_set_i),
    .flag_clr_i  (flag_clr_i),
    .uaddr_o     (uaddr_o),
    .flags_o     (flags_o),
    .xl_hit      (xl_hit),
    .xl_addr     (xl_addr)
);

// File: tb/sim_mseq_core.sv
// Bench: sweeps jumps, flag commands and translation inputs, and checks
// every next address against an arithmetic model of the requirements.
module sim_mseq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_en_i = 1'b0;
    logic [10:0] jump_addr_i = '0;
    logic        call_save_i = 1'b0;
    logic        ret_load_i = 1'b0;
    logic        xlat_en_i = 1'b0;
    logic [2:0]  flag_set_i = '0;
    logic [2:0]  flag_clr_i = '0;
    logic [15:0] instr_i = '0;
    logic [3:0]  irq_i = '0;
    logic [10:0] uaddr_o;
    logic [2:0]  flags_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [10:0] m_lc = '0;
    logic [10:0] m_rr = '0;
    logic [2:0]  m_fl = '0;

    always #10 clk = ~clk;

    mseq_core u0 (
        .clk(clk), .rst_n(rst_n), .jump_en_i(jump_en_i), .jump_addr_i(jump_addr_i),
        .call_save_i(call_save_i), .ret_load_i(ret_load_i), .xlat_en_i(xlat_en_i),
        .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i), .instr_i(instr_i),
        .irq_i(irq_i), .uaddr_o(uaddr_o), .flags_o(flags_o)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R2 watchdog cycles %0d expected below %0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Default table model from R9
    function automatic void model_xlat(input logic [10:0] lc, input logic [15:0] ir,
                                       input logic [3:0] iq, input logic [2:0] fl,
                                       output bit hit, output logic [10:0] a);
        hit = 1'b1;
        a = '0;
        if (lc == 11'h010 && iq[3])      a = 11'h700;
        else if (lc == 11'h010 && iq[2]) a = 11'h710;
        else if (lc == 11'h010 && iq[1]) a = 11'h720;
        else if (lc == 11'h010 && iq[0]) a = 11'h730;
        else if (lc == 11'h010 && fl[0]) a = 11'h740;
        else if (lc == 11'h020 && ir[15:12] == 4'h1) a = 11'h100;
        else if (lc == 11'h020 && ir[15:12] == 4'h2) a = 11'h200;
        else if (lc == 11'h020 && ir[15] && fl[1])   a = 11'h300;
        else hit = 1'b0;
    endfunction

    // One control word: drive, advance the model, clock, check outputs
    task automatic go(input string tag, input bit j, input logic [10:0] t, input bit sv,
                      input bit rt, input bit xl, input logic [2:0] fs, input logic [2:0] fc,
                      input logic [15:0] ir, input logic [3:0] iq);
        bit hit;
        logic [10:0] xa;
        logic [10:0] nl;
        jump_en_i = j; jump_addr_i = t; call_save_i = sv; ret_load_i = rt;
        xlat_en_i = xl; flag_set_i = fs; flag_clr_i = fc; instr_i = ir; irq_i = iq;
        model_xlat(m_lc, ir, iq, m_fl, hit, xa);
        if (xl)      nl = hit ? xa : m_lc + 11'd1;
        else if (rt) nl = m_rr;
        else if (j)  nl = t;
        else         nl = m_lc + 11'd1;
        if (sv) m_rr = m_lc + 11'd1;
        m_fl = (m_fl & ~fc) | fs;
        m_lc = nl;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "uaddr", int'(uaddr_o), int'(m_lc));
        chk(tag, "flags", int'(flags_o), int'(m_fl));
    endtask

    task automatic idle(input string tag);
        go(tag, 0, '0, 0, 0, 0, '0, '0, '0, '0);
    endtask

    task automatic jmp(input string tag, input logic [10:0] t);
        go(tag, 1, t, 0, 0, 0, '0, '0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "uaddr", int'(uaddr_o), 0);
        chk("R1", "flags", int'(flags_o), 0);
        rst_n = 1'b1;

        // R2: plain stepping, then wrap at the top of the space
        for (int i = 0; i < 40; i++) idle("R2");
        jmp("R3", 11'h7FE);
        idle("R2");
        idle("R2");

        // R3: every jump target
        for (int t = 0; t < 2048; t++) jmp("R3", 11'(t));

        // R4: call, wander, return; return beats jump
        for (int k = 0; k < 16; k++) begin
            jmp("R3", 11'(k * 131));
            go("R4", 1, 11'(11'h400 + k), 1, 0, 0, '0, '0, '0, '0);
            idle("R2");
            if (k[0]) go("R4", 1, 11'h055, 0, 1, 0, '0, '0, '0, '0);
            else      go("R4", 0, '0, 0, 1, 0, '0, '0, '0, '0);
        end
        // R4: save and return in one word use the older return value
        jmp("R3", 11'h123);
        go("R4", 1, 11'h300, 1, 0, 0, '0, '0, '0, '0);
        jmp("R3", 11'h555);
        go("R4", 0, '0, 1, 1, 0, '0, '0, '0, '0);
        go("R4", 0, '0, 0, 1, 0, '0, '0, '0, '0);

        // R6: every start state against every set/clear pair
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 8; a++)
                for (int c = 0; c < 8; c++) begin
                    go("R6", 0, '0, 0, 0, 0, 3'(s), ~3'(s), '0, '0);
                    go("R6", 0, '0, 0, 0, 0, 3'(a), 3'(c), '0, '0);
                end

        // R5/R7/R9: interrupt arbitration at 0x010 with jump and return raised
        for (int f = 0; f < 8; f++)
            for (int q = 0; q < 16; q++) begin
                go("R9", 1, 11'h010, 0, 0, 0, 3'(f), ~3'(f), '0, '0);
                go("R5", q[0], 11'h555, q[1], f[2], 1, '0, '0, 16'h1000, 4'(q));
            end

        // R7/R9: opcode decode at 0x020
        for (int f = 0; f < 8; f++)
            for (int n = 0; n < 16; n++) begin
                go("R7", 1, 11'h020, 0, 0, 0, 3'(f), ~3'(f), '0, '0);
                go("R9", n[1], 11'h2AA, 0, n[2], 1, '0, '0, {4'(n), 12'h5A5}, 4'hF);
            end

        // R8: translation elsewhere misses and steps, including at the wrap
        for (int k = 0; k < 8; k++) begin
            jmp("R3", (k == 7) ? 11'h7FF : 11'(11'h011 + k * 37));
            go("R8", 1, 11'h066, 0, 1, 1, '0, '0, 16'h1000, 4'hF);
        end

        // R1: reset mid-run clears counter, return register and flags
        go("R1", 1, 11'h234, 1, 0, 0, 3'h7, '0, '0, '0);
        rst_n = 1'b0;
        jump_en_i = 1'b1; jump_addr_i = 11'h3C3; flag_set_i = 3'h7;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_lc = '0; m_rr = '0; m_fl = '0;
        chk("R1", "uaddr", int'(uaddr_o), 0);
        chk("R1", "flags", int'(flags_o), 0);
        go("R1", 0, '0, 0, 1, 0, '0, '0, '0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule